// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a flash memory and decides when an embedded program or erase operation inside the device has ended. After a start strobe it issues status reads over a simple request/acknowledge read bus. It then judges each returned byte by one of two methods, picked at start: a completion-bit comparison on bit 7, or a toggle check on bit 6. It reports the outcome as a one-cycle pass or fail pulse and keeps a count of the reads it made.

In the bit-7 method the device returns the inverse of the written bit 7 while a program runs. During an erase it returns 0 and then 1 once the erase is done. The caller therefore supplies the byte it wrote, or 0xFF for an erase. In the toggle method the device flips bit 6 on each read while it is busy. In both methods, bit 5 set means the device has exceeded its time limit. The device can finish and raise bit 5 on the same read, so a set bit 5 never ends the poll at once: one more judgement is always made first. An optional cap on the number of reads turns a device that never finishes into a fail.

Top module: `done_poller`

## Requirements
- R1: After reset, rdReq, passPulse and failPulse are low and readCount is 0.
- R2: rdReq stays high with rdAddr stable and equal to the pollAddr latched at start until a cycle with rdAck high. Each such cycle increments readCount by one, and readCount is cleared by an accepted start.
- R3: With useToggle=0, the poll passes on the first read whose bit 7 equals bit 7 of expData.
- R4: With useToggle=0, a read whose bit 7 differs from expData bit 7 and whose bit 5 is 0 leads to another read.
- R5: With useToggle=0, a non-matching read with bit 5 set leads to exactly one more read. That read passes if its bit 7 matches and fails otherwise, and no further reads follow.
- R6: With useToggle=1, the first read after start is never judged. Each later read passes when its bit 6 equals bit 6 of the read just before it, so the earliest possible pass comes on the second read.
- R7: With useToggle=1, a read whose bit 6 changed and whose bit 5 is set leads to exactly one more read. That read passes if its bit 6 equals the previous read's bit 6 and fails otherwise.
- R8: When MAX_READS is nonzero and MAX_READS reads have completed without a pass, the poll fails and readCount never exceeds MAX_READS.
- R9: passPulse and failPulse are single-cycle, never high together, and after either one rdReq stays low until the next start.
- R10: startStrb is ignored while a poll is in progress: the poll address, method and expected byte do not change and readCount is not cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startStrb | input | 1 | Begin a poll (accepted when idle) |
| useToggle | input | 1 | 0: bit-7 comparison, 1: bit-6 toggle check |
| pollAddr | input | ADDR_W | Address to read status from |
| expData | input | 8 | Byte written by the operation (0xFF for erase) |
| rdReq | output | 1 | Read request, held until acknowledged |
| rdAddr | output | ADDR_W | Read address |
| rdAck | input | 1 | Read acknowledge; rdData valid in the same cycle |
| rdData | input | 8 | Status byte returned by the device |
| passPulse | output | 1 | One-cycle pulse: operation completed |
| failPulse | output | 1 | One-cycle pulse: timeout or read cap reached |
| readCount | output | CNT_W | Reads completed since the last accepted start |

## Verification
The checker watches bus conduct and outcome signalling on every cycle. It checks that a request holds its address until acknowledged and that each acknowledge advances the read count by exactly one. It also checks that the outcome pulses are single, exclusive and followed by a silent bus, and that the count stays within the cap. Only the bench's scripted status sequences can show that the right outcome arrives after the right number of reads. These cover the immediate match, the bit-5 recheck that rescues or condemns a poll, toggle priming and the ignored restart.

// File: rtl/done_poller_pkg.sv
package done_poller_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;      // accept start: latch request, clear count
    logic capture;   // read acknowledged: latch status, count it
    logic shiftPrev; // judging a read: keep its bit 6 for next time
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_EVAL = 2'd2
  } pollState_t;

  localparam int BIT_DONE    = 7;
  localparam int BIT_TOGGLE  = 6;
  localparam int BIT_TIMEOUT = 5;

endpackage

// File: rtl/poll_dpath.sv
module poll_dpath
  import done_poller_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int CNT_W     = 16,
  parameter int MAX_READS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [7:0]        expData,
  input  logic [7:0]        rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [CNT_W-1:0]  readCount,
  output logic              bit7Match,
  output logic              bit6Moved,
  output logic              timeoutSeen,
  output logic              capHit
);

  localparam logic [CNT_W-1:0] CAP_VAL = CNT_W'(MAX_READS);

  logic [ADDR_W-1:0] addrQ;
  logic              expBit7Q;
  logic [7:0]        dataQ;
  logic              prevBit6Q;
  logic [CNT_W-1:0]  countQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      expBit7Q  <= 1'b0;
      dataQ     <= '0;
      prevBit6Q <= 1'b0;
      countQ    <= '0;
    end else begin
      if (strobe.load) begin
        addrQ    <= pollAddr;
        expBit7Q <= expData[BIT_DONE];
        countQ   <= '0;
      end
      if (strobe.capture) begin
        dataQ  <= rdData;
        countQ <= countQ + 1'b1;
      end
      if (strobe.shiftPrev) begin
        prevBit6Q <= dataQ[BIT_TOGGLE];
      end
    end
  end

  assign rdAddr      = addrQ;
  assign readCount   = countQ;
  assign bit7Match   = (dataQ[BIT_DONE] == expBit7Q);
  assign bit6Moved   = (dataQ[BIT_TOGGLE] != prevBit6Q);
  assign timeoutSeen = dataQ[BIT_TIMEOUT];

  generate
    if (MAX_READS == 0) begin : g_noCap
      assign capHit = 1'b0;
    end else begin : g_cap
      assign capHit = (countQ >= CAP_VAL);
    end
  endgenerate

endmodule

// File: rtl/poll_ctrl.sv
module poll_ctrl
  import done_poller_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startStrb,
  input  logic      useToggle,
  input  logic      rdAck,
  input  logic      bit7Match,
  input  logic      bit6Moved,
  input  logic      timeoutSeen,
  input  logic      capHit,
  output logic      rdReq,
  output logic      passPulse,
  output logic      failPulse,
  output dpStrobe_t strobe
);

  pollState_t state;
  logic toggleModeQ;
  logic primeQ;
  logic recheckQ;
  logic passQ;
  logic failQ;

  logic judged;
  logic passNow;
  logic failNow;
  logic armRecheck;

  always_comb begin
    judged     = !(toggleModeQ && primeQ);
    passNow    = judged && (toggleModeQ ? !bit6Moved : bit7Match);
    failNow    = !passNow && ((judged && recheckQ) || capHit);
    armRecheck = judged && !passNow && timeoutSeen;
  end

  always_comb begin
    strobe.load      = (state == ST_IDLE) && startStrb;
    strobe.capture   = (state == ST_REQ) && rdAck;
    strobe.shiftPrev = (state == ST_EVAL);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      toggleModeQ <= 1'b0;
      primeQ      <= 1'b0;
      recheckQ    <= 1'b0;
      passQ       <= 1'b0;
      failQ       <= 1'b0;
    end else begin
      passQ <= (state == ST_EVAL) && passNow;
      failQ <= (state == ST_EVAL) && failNow;
      unique case (state)
        ST_IDLE: begin
          if (startStrb) begin
            toggleModeQ <= useToggle;
            primeQ      <= 1'b1;
            recheckQ    <= 1'b0;
            state       <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (rdAck) state <= ST_EVAL;
        end
        ST_EVAL: begin
          primeQ <= 1'b0;
          if (armRecheck) recheckQ <= 1'b1;
          state <= (passNow || failNow) ? ST_IDLE : ST_REQ;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rdReq     = (state == ST_REQ);
  assign passPulse = passQ;
  assign failPulse = failQ;

endmodule

// File: rtl/done_poller.sv
module done_poller
  import done_poller_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int CNT_W     = 16,
  parameter int MAX_READS = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startStrb,
  input  logic              useToggle,
  input  logic [ADDR_W-1:0] pollAddr,
  input  logic [7:0]        expData,
  output logic              rdReq,
  output logic [ADDR_W-1:0] rdAddr,
  input  logic              rdAck,
  input  logic [7:0]        rdData,
  output logic              passPulse,
  output logic              failPulse,
  output logic [CNT_W-1:0]  readCount
);

  dpStrobe_t strobe;
  logic bit7Match;
  logic bit6Moved;
  logic timeoutSeen;
  logic capHit;

  poll_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startStrb  (startStrb),
    .useToggle  (useToggle),
    .rdAck      (rdAck),
    .bit7Match  (bit7Match),
    .bit6Moved  (bit6Moved),
    .timeoutSeen(timeoutSeen),
    .capHit     (capHit),
    .rdReq      (rdReq),
    .passPulse  (passPulse),
    .failPulse  (failPulse),
    .strobe     (strobe)
  );

  poll_dpath #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .MAX_READS(MAX_READS)
  ) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .pollAddr   (pollAddr),
    .expData    (expData),
    .rdData     (rdData),
    .rdAddr     (rdAddr),
    .readCount  (readCount),
    .bit7Match  (bit7Match),
    .bit6Moved  (bit6Moved),
    .timeoutSeen(timeoutSeen),
    .capHit     (capHit)
  );

endmodule

// File: rtl/done_poller_chk.sv
module done_poller_chk #(
  parameter int ADDR_W    = 20,
  parameter int CNT_W     = 16,
  parameter int MAX_READS = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              startStrb,
  input logic              useToggle,
  input logic [ADDR_W-1:0] pollAddr,
  input logic [7:0]        expData,
  input logic              rdReq,
  input logic [ADDR_W-1:0] rdAddr,
  input logic              rdAck,
  input logic [7:0]        rdData,
  input logic              passPulse,
  input logic              failPulse,
  input logic [CNT_W-1:0]  readCount
);

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rstN)
    !(passPulse && failPulse)); // R9

  AST_PASS_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    passPulse |=> !passPulse); // R9

  AST_FAIL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    failPulse |=> !failPulse); // R9

  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (passPulse || failPulse) |-> !rdReq); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && !rdAck) |=> (rdReq && $stable(rdAddr))); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (rdReq && rdAck) |=> (readCount == $past(readCount) + 1'b1)); // R2

  AST_PASS_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    passPulse |-> (readCount != '0)); // R3

  generate
    if (MAX_READS != 0) begin : g_capChk
      AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
        readCount <= CNT_W'(MAX_READS)); // R8
    end
  endgenerate

endmodule

bind done_poller done_poller_chk #(
  .ADDR_W   (ADDR_W),
  .CNT_W    (CNT_W),
  .MAX_READS(MAX_READS)
) u_chk (.*);

// File: tb/sim_done_poller.sv
module sim_done_poller;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 20;
  localparam int CNT_W      = 8;
  localparam int MAX_READS  = 6;

  logic              clk = 1'b0;
  logic              rstN;
  logic              startStrb;
  logic              useToggle;
  logic [ADDR_W-1:0] pollAddr;
  logic [7:0]        expData;
  logic              rdReq;
  logic [ADDR_W-1:0] rdAddr;
  logic              rdAck;
  logic [7:0]        rdData;
  logic              passPulse;
  logic              failPulse;
  logic [CNT_W-1:0]  readCount;

  int errors = 0;
  int checks = 0;

  logic [7:0]        script [0:3];
  logic [7:0]        fillByte;
  int                scriptLen;
  int                idx;
  logic [ADDR_W-1:0] monAddr;
  int                addrErrs;

  logic gotPass, gotFail;
  int   gotCount;

  always #(CLK_PERIOD/2) clk = ~clk;

  done_poller #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_READS(MAX_READS)
  ) u0 (
    .clk(clk), .rstN(rstN), .startStrb(startStrb), .useToggle(useToggle),
    .pollAddr(pollAddr), .expData(expData), .rdReq(rdReq), .rdAddr(rdAddr),
    .rdAck(rdAck), .rdData(rdData), .passPulse(passPulse),
    .failPulse(failPulse), .readCount(readCount)
  );

  // Scripted device: answers each request one cycle after seeing it
  initial begin
    rdAck = 1'b0;
    rdData = 8'h00;
    forever begin
      @(negedge clk);
      if (rdReq && !rdAck) begin
        rdAck = 1'b1;
        rdData = (idx < scriptLen) ? script[idx] : fillByte;
        if (rdAddr !== monAddr) addrErrs++;
        idx++;
      end else begin
        rdAck = 1'b0;
      end
    end
  end

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setScript(input int n, input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] fill);
    script[0] = b0; script[1] = b1; script[2] = b2; script[3] = b3;
    scriptLen = n; fillByte = fill; idx = 0; addrErrs = 0;
  endtask

  task automatic runPoll(input logic mode, input logic [ADDR_W-1:0] a, input logic [7:0] e);
    monAddr = a;
    @(negedge clk);
    startStrb = 1'b1; useToggle = mode; pollAddr = a; expData = e;
    @(negedge clk);
    startStrb = 1'b0;
    gotPass = 1'b0; gotFail = 1'b0; gotCount = -1;
    for (int i = 0; i < 300; i++) begin
      if (passPulse || failPulse) begin
        gotPass = passPulse; gotFail = failPulse; gotCount = int'(readCount);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic checkRun(input string tag, input logic expPass, input int expCnt);
    check({tag, " outcome"}, (gotPass == expPass) && (gotFail == !expPass),
          int'({gotPass, gotFail}), int'({expPass, !expPass}));
    check({tag, " reads"}, gotCount == expCnt, gotCount, expCnt);
    check({tag, " address"}, addrErrs == 0, addrErrs, 0);
  endtask

  task automatic t_reset;
    check("R1 rdReq", rdReq == 1'b0, int'(rdReq), 0);
    check("R1 pulses", !passPulse && !failPulse, int'({passPulse, failPulse}), 0);
    check("R1 count", readCount == '0, int'(readCount), 0);
  endtask

  task automatic t_bit7Basic;
    setScript(3, 8'h00, 8'h00, 8'h80, 8'h00, 8'h80);
    runPoll(1'b0, 20'hA5A5A, 8'hFF);
    checkRun("R4 R2 erase poll", 1'b1, 3);
    @(negedge clk);
    check("R9 pulse width", !passPulse && !rdReq, int'({passPulse, rdReq}), 0);
    setScript(1, 8'h55, 8'h00, 8'h00, 8'h00, 8'h55);
    runPoll(1'b0, 20'h00011, 8'h55);
    checkRun("R3 immediate", 1'b1, 1);
    setScript(2, 8'h80, 8'h12, 8'h00, 8'h00, 8'h12);
    runPoll(1'b0, 20'h12345, 8'h12);
    checkRun("R3 program complement", 1'b1, 2);
  endtask

  task automatic t_bit7Timeout;
    setScript(3, 8'h00, 8'h20, 8'hA0, 8'h00, 8'hA0);
    runPoll(1'b0, 20'h0F000, 8'hFF);
    checkRun("R5 recheck pass", 1'b1, 3);
    setScript(3, 8'h00, 8'h20, 8'h20, 8'h00, 8'h20);
    runPoll(1'b0, 20'h0F001, 8'hFF);
    checkRun("R5 recheck fail", 1'b0, 3);
    repeat (8) @(negedge clk);
    check("R5 no extra read", (idx == 3) && !rdReq, idx, 3);
  endtask

  task automatic t_toggle;
    setScript(4, 8'h40, 8'h00, 8'h40, 8'h40, 8'h40);
    runPoll(1'b1, 20'h00300, 8'h00);
    checkRun("R6 toggle settle", 1'b1, 4);
    setScript(2, 8'h40, 8'h40, 8'h00, 8'h00, 8'h40);
    runPoll(1'b1, 20'h00301, 8'h00);
    checkRun("R6 prime only", 1'b1, 2);
    setScript(3, 8'h00, 8'h60, 8'h60, 8'h00, 8'h60);
    runPoll(1'b1, 20'h00302, 8'h00);
    checkRun("R7 recheck pass", 1'b1, 3);
    setScript(3, 8'h00, 8'h60, 8'h20, 8'h00, 8'h20);
    runPoll(1'b1, 20'h00303, 8'h00);
    checkRun("R7 recheck fail", 1'b0, 3);
  endtask

  task automatic t_cap;
    setScript(0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    runPoll(1'b0, 20'h77777, 8'hFF);
    checkRun("R8 read cap", 1'b0, MAX_READS);
  endtask

  task automatic t_restartIgnored;
    setScript(3, 8'h00, 8'h00, 8'h80, 8'h00, 8'h80);
    monAddr = 20'h0ABCD;
    @(negedge clk);
    startStrb = 1'b1; useToggle = 1'b0; pollAddr = 20'h0ABCD; expData = 8'hFF;
    @(negedge clk);
    startStrb = 1'b0;
    while (idx < 1) @(negedge clk);
    @(negedge clk);
    startStrb = 1'b1; useToggle = 1'b1; pollAddr = 20'h11111; expData = 8'h00;
    @(negedge clk);
    startStrb = 1'b0;
    gotPass = 1'b0; gotFail = 1'b0; gotCount = -1;
    for (int i = 0; i < 300; i++) begin
      if (passPulse || failPulse) begin
        gotPass = passPulse; gotFail = failPulse; gotCount = int'(readCount);
        break;
      end
      @(negedge clk);
    end
    checkRun("R10 restart ignored", 1'b1, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; startStrb = 1'b0; useToggle = 1'b0;
    pollAddr = '0; expData = '0;
    scriptLen = 0; fillByte = 8'h00; idx = 0; monAddr = '0; addrErrs = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_bit7Basic();
    t_bit7Timeout();
    t_toggle();
    t_cap();
    t_restartIgnored();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule